// File: doc/BRIEF.md
# Oversampling Serial Transceiver with Receiver Standby

This block is a full-duplex asynchronous serial transceiver that uses NRZ framing. Each frame carries one low start bit, then 8 or 9 data bits sent least significant bit first, then one high stop bit. A static mode input selects the data length. The block has no baud generator. It runs from a tick that marks sixteen sampling instants per bit, and it may be held high on every clock.

The receiver resynchronizes on every high-to-low transition in the incoming stream. It decides each data bit by a majority of three samples around the middle of the bit. It judges the start bit and the stop bit from seven samples each. Software can put the receiver into a standby state. In that state whole characters are parsed and then dropped. The receiver leaves standby on its own after one character time of idle line, so it is ready for the first character of the next message.

The transmitter has one holding slot that accepts a data character, a whole idle character (all ones) or a whole break character (all zeros). It reports when the slot is empty, and it reports separately when the shifter has finished and nothing is waiting.

Top module: `uart_top`

## Requirements
- R1: On the line, a frame is a start bit of 0, then the data bits least significant bit first (8 when nine_bit=0, 9 when nine_bit=1), then a stop bit of 1. Each bit lasts 16 ticks, and an idle txd is 1.
- R2: A received character appears on rx_data with rx_valid=1 before its stop bit ends. A one-cycle rx_rd pulse clears rx_valid. In 8-bit mode rx_data[8] is 0.
- R3: Tick 0 of a bit is the tick at which its opening falling edge is seen. Each data bit takes the majority value of the samples at ticks 7, 8 and 9 of that bit, so one wrong sample does not change the result.
- R4: The start bit is sampled at ticks 4 to 10. If four or more of those samples are high, the start is discarded and the receiver goes back to hunting for an edge. A single wrong sample is tolerated.
- R5: The stop bit is sampled at ticks 4 to 10. If fewer than four samples are high, rx_frame_err=1 is delivered with the character; otherwise rx_frame_err=0.
- R6: A falling edge seen at bit phase 12 to 15 begins the next bit at that tick. A falling edge seen at phase 1 to 3 restarts the current bit at phase 0. Other edges do not move the timing. An alternating-data frame sent at 15 or 17 ticks per bit is received without error.
- R7: A pulse on rx_sleep_req sets rx_asleep=1. While asleep, characters are not delivered: rx_valid stays 0 and rx_data keeps its value. rx_asleep clears after the line has been high for 16 x (10 or 11) consecutive ticks, counted from the request. The next character is then delivered.
- R8: An idle request sends a whole character of ones and a break request sends a whole character of zeros. Each lasts the full frame length (160 ticks for 8-bit, 176 for 9-bit). Queued characters follow one another on txd with no gap.
- R9: tx_empty=1 means the holding slot is free. A write or request made while tx_empty=0 is ignored. When requests arrive in the same cycle, data wins over break and break wins over idle.
- R10: tx_done=1 only when the shifter is idle and no character is pending. It is 0 while any character is being sent.
- R11: After reset: txd=1, tx_empty=1, tx_done=1, rx_valid=0, rx_frame_err=0 and rx_asleep=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick, 16 per bit |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| tx_wdata | input | 9 | Character to transmit |
| tx_wr | input | 1 | Write strobe for tx_wdata |
| tx_idle_req | input | 1 | Queue one idle character |
| tx_brk_req | input | 1 | Queue one break character |
| tx_empty | output | 1 | Holding slot free |
| tx_done | output | 1 | Shifter idle and nothing pending |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_sleep_req | input | 1 | Enter receiver standby |
| rx_rd | input | 1 | Read strobe, clears rx_valid |
| rx_data | output | 9 | Last delivered character |
| rx_valid | output | 1 | A delivered character is unread |
| rx_frame_err | output | 1 | Stop bit of the delivered character judged low |
| rx_asleep | output | 1 | Receiver in standby |

## Verification
The bench puts one wrong sample inside a start bit and inside data bits. A design that votes on a single sample, or in the wrong window, would deliver a corrupted character. It sends a short low pulse and then alternating frames at 15 and 17 ticks per bit: a receiver without false-start rejection would produce a phantom character, and one without edge realignment would return wrong data or a framing error. Standby is tested with back-to-back frames, a partial idle gap and a full idle gap, which shows an early wake or a missing wake. On the transmit side the bench measures exact break and idle lengths. It also checks that a write into a full slot is ignored and that data takes priority over a break requested in the same cycle; a wrong design would send an extra frame, a gap, or the wrong character.

// File: rtl/uart_pkg.sv
package uart_pkg;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        Q_NONE,
        Q_DATA,
        Q_IDLE,
        Q_BREAK
    } tx_kind_t;

    // Votes: data bits use three samples, start and stop use seven.
    localparam logic [2:0] DATA_VOTES = 3'd3;
    localparam logic [2:0] EDGE_VOTES = 3'd7;

    // True when more than half of n samples were high.
    function automatic logic over_half(input logic [2:0] ones, input logic [2:0] n);
        return ({ones, 1'b0}) > {1'b0, n};
    endfunction

endpackage

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          nine,
    input  logic          rxd,
    input  logic          sleep_req,
    input  logic          rd,
    output logic [DW-1:0] data,
    output logic          valid,
    output logic          ferr,
    output logic          asleep
);
    localparam int PW = $clog2(OSR);
    localparam int BW = $clog2(DW + 1);
    localparam int IW = $clog2(OSR * (DW + 2) + 1);
    localparam int CW = 3;
    localparam logic [PW-1:0] MID     = PW'(OSR / 2);
    localparam logic [PW-1:0] DLO     = MID - 1'b1;
    localparam logic [PW-1:0] DHI     = MID + 1'b1;
    localparam logic [PW-1:0] ELO     = MID - PW'(4);
    localparam logic [PW-1:0] EHI     = MID + PW'(2);
    localparam logic [PW-1:0] LAST    = PW'(OSR - 1);
    localparam logic [PW-1:0] EARLY   = PW'(OSR - 4);
    localparam logic [PW-1:0] LATE    = PW'(3);

    logic          s1, s2, prev;
    rx_state_t     st;
    logic [PW-1:0] ph, cur_raw, cur;
    logic [BW-1:0] bi, nbits;
    logic [CW-1:0] cnt, ones_now;
    logic [DW-1:0] shr;
    logic [IW-1:0] idle_cnt, lim;
    logic          fall, early, late, adv, in_win, decide, dlv;

    always_comb begin
        nbits   = nine ? BW'(DW) : BW'(DW - 1);
        lim     = nine ? IW'(OSR * (DW + 2)) : IW'(OSR * (DW + 1));
        fall    = tick && prev && !s2;
        cur_raw = (ph == LAST) ? '0 : ph + 1'b1;
        early   = fall && (cur_raw >= EARLY);
        late    = fall && (cur_raw <= LATE);
        cur     = (early || late) ? '0 : cur_raw;
        adv     = (cur_raw == '0) || early;
        if (st == RX_DATA) begin
            in_win = (cur >= DLO) && (cur <= DHI);
            decide = (cur == DHI);
        end else begin
            in_win = (st != RX_HUNT) && (cur >= ELO) && (cur <= EHI);
            decide = (st != RX_HUNT) && (cur == EHI);
        end
        ones_now = cnt + ((in_win && s2) ? CW'(1) : CW'(0));
        dlv      = tick && (st == RX_STOP) && !adv && decide && !asleep;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
            st <= RX_HUNT; ph <= '0; bi <= '0; cnt <= '0; shr <= '0;
            data <= '0; valid <= 1'b0; ferr <= 1'b0; asleep <= 1'b0;
            idle_cnt <= '0;
        end else begin
            s1 <= rxd;
            s2 <= s1;
            if (rd) valid <= 1'b0;
            if (dlv) begin
                valid <= 1'b1;
                data  <= nine ? shr : (shr >> 1);
                ferr  <= !over_half(ones_now, EDGE_VOTES);
            end
            if (tick) begin
                prev <= s2;
                if (!s2) idle_cnt <= '0;
                else if (idle_cnt != lim) idle_cnt <= idle_cnt + 1'b1;
                if (asleep && s2 && (idle_cnt + 1'b1 == lim)) asleep <= 1'b0;
                if (st == RX_HUNT) begin
                    if (fall) begin
                        st  <= RX_START;
                        ph  <= '0;
                        cnt <= '0;
                    end
                end else begin
                    ph <= cur;
                    if (adv) begin
                        cnt <= '0;
                        if (st == RX_START) begin
                            st <= RX_DATA;
                            bi <= '0;
                        end else if (st == RX_DATA) begin
                            if (bi == nbits - 1'b1) st <= RX_STOP;
                            else bi <= bi + 1'b1;
                        end
                    end else if (decide) begin
                        cnt <= '0;
                        if (st == RX_START && over_half(ones_now, EDGE_VOTES)) st <= RX_HUNT;
                        if (st == RX_DATA) shr <= {over_half(ones_now, DATA_VOTES), shr[DW-1:1]};
                        if (st == RX_STOP) st <= RX_HUNT;
                    end else if (late) begin
                        cnt <= '0;
                    end else if (in_win) begin
                        cnt <= ones_now;
                    end
                end
            end
            if (sleep_req) begin
                asleep   <= 1'b1;
                idle_cnt <= '0;
            end
        end
    end

    // R2: a read with no delivery in the same cycle leaves nothing unread
    assert_rd_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (rd && !dlv) |=> !valid);
    // R7: a fresh character never shows up while the receiver was in standby
    assert_no_deliver_asleep_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> !$past(asleep));
    // R7: standby ends only after the line was seen high
    assert_wake_on_high_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(asleep) |-> $past(s2));
    // R1: the data bit index stays inside the selected length
    assert_bit_index_R1: assert property (@(posedge clk) disable iff (rst)
        (st == RX_DATA) |-> (bi < nbits));

endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          nine,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          idle_req,
    input  logic          brk_req,
    output logic          txd,
    output logic          empty,
    output logic          done
);
    localparam int FW = DW + 2;
    localparam int LW = $clog2(FW + 1);
    localparam int PW = $clog2(OSR);
    localparam logic [PW-1:0] LAST = PW'(OSR - 1);

    tx_kind_t      pend, kind;
    logic [DW-1:0] pdata;
    logic [FW-1:0] sh, frame;
    logic [LW-1:0] left, nb;
    logic [PW-1:0] ph;
    logic          busy, fin;

    always_comb begin
        nb = nine ? LW'(DW + 2) : LW'(DW + 1);
        case (pend)
            Q_DATA:  frame = nine ? {1'b1, pdata, 1'b0} : {2'b11, pdata[DW-2:0], 1'b0};
            Q_BREAK: frame = '0;
            default: frame = '1;
        endcase
        fin   = busy && tick && (ph == LAST) && (left == LW'(1));
        txd   = busy ? sh[0] : 1'b1;
        empty = (pend == Q_NONE);
        done  = !busy && (pend == Q_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= Q_NONE; kind <= Q_NONE; pdata <= '0;
            sh <= '1; left <= '0; ph <= '0; busy <= 1'b0;
        end else begin
            if ((!busy || fin) && pend != Q_NONE) begin
                busy <= 1'b1;
                ph   <= '0;
                left <= nb;
                sh   <= frame;
                kind <= pend;
                pend <= Q_NONE;
            end else if (busy && tick) begin
                if (ph == LAST) begin
                    ph   <= '0;
                    sh   <= {1'b1, sh[FW-1:1]};
                    left <= left - 1'b1;
                    if (left == LW'(1)) busy <= 1'b0;
                end else begin
                    ph <= ph + 1'b1;
                end
            end
            if (pend == Q_NONE) begin
                if (wr) begin
                    pend  <= Q_DATA;
                    pdata <= wdata;
                end else if (brk_req) begin
                    pend <= Q_BREAK;
                end else if (idle_req) begin
                    pend <= Q_IDLE;
                end
            end
        end
    end

    // R9: a pending character is taken by an idle shifter on the next edge
    assert_pending_loads_R9: assert property (@(posedge clk) disable iff (rst)
        (pend != Q_NONE && !busy) |=> busy);
    // R8: an idle character keeps the line high for its whole length
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == Q_IDLE) |-> txd);
    // R8: a break character keeps the line low for its whole length
    assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == Q_BREAK) |-> !txd);
    // R10: completion appears only when a character has just finished
    assert_done_after_frame_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

endmodule

// File: rtl/uart_top.sv
module uart_top #(
    parameter int OSR = 16,
    parameter int DW  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          nine_bit,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_wr,
    input  logic          tx_idle_req,
    input  logic          tx_brk_req,
    output logic          tx_empty,
    output logic          tx_done,
    output logic          txd,
    input  logic          rxd,
    input  logic          rx_sleep_req,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          rx_frame_err,
    output logic          rx_asleep
);

    uart_tx #(.OSR(OSR), .DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .nine     (nine_bit),
        .wr       (tx_wr),
        .wdata    (tx_wdata),
        .idle_req (tx_idle_req),
        .brk_req  (tx_brk_req),
        .txd      (txd),
        .empty    (tx_empty),
        .done     (tx_done)
    );

    uart_rx #(.OSR(OSR), .DW(DW)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .nine      (nine_bit),
        .rxd       (rxd),
        .sleep_req (rx_sleep_req),
        .rd        (rx_rd),
        .data      (rx_data),
        .valid     (rx_valid),
        .ferr      (rx_frame_err),
        .asleep    (rx_asleep)
    );

endmodule

// File: tb/sim_uart_top.sv
module sim_uart_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_T = 16;

    // {nine, stop value, data}
    localparam logic [10:0] VEC [0:5] = '{
        {1'b0, 1'b1, 9'h0A5},
        {1'b0, 1'b1, 9'h000},
        {1'b0, 1'b1, 9'h0FF},
        {1'b1, 1'b1, 9'h1A5},
        {1'b1, 1'b1, 9'h100},
        {1'b0, 1'b0, 9'h03C}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       nine = 1'b0;
    logic [8:0] wdata = '0;
    logic       wr = 1'b0, idle_req = 1'b0, brk_req = 1'b0;
    logic       tx_empty, tx_done, txd;
    logic       rxd = 1'b1, sleep_req = 1'b0, rd = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, ferr, asleep;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_top u0 (
        .clk(clk), .rst(rst), .tick(tick), .nine_bit(nine),
        .tx_wdata(wdata), .tx_wr(wr), .tx_idle_req(idle_req), .tx_brk_req(brk_req),
        .tx_empty(tx_empty), .tx_done(tx_done), .txd(txd),
        .rxd(rxd), .rx_sleep_req(sleep_req), .rx_rd(rd),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(ferr), .rx_asleep(asleep)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic nb, input logic [8:0] d, input logic sv, input int per);
        hold(1'b0, per);
        for (int i = 0; i < (nb ? 9 : 8); i++) hold(d[i], per);
        hold(sv, per);
        rxd = 1'b1;
    endtask

    // 8-bit frame, one wrong sample at tick 6 of the start bit and tick 8 of data bit gi
    task automatic send_glitch(input logic [7:0] d, input int gi);
        hold(1'b0, 6); hold(1'b1, 1); hold(1'b0, 9);
        for (int i = 0; i < 8; i++) begin
            if (i == gi) begin
                hold(d[i], 8); hold(!d[i], 1); hold(d[i], 7);
            end else begin
                hold(d[i], BIT_T);
            end
        end
        hold(1'b1, BIT_T);
    endtask

    task automatic pulse_rd();
        rd = 1'b1; @(negedge clk); rd = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [8:0] d);
        wdata = d; wr = 1'b1; @(negedge clk); wr = 1'b0;
    endtask

    task automatic cap_tx(input logic nb, output logic [8:0] d, output logic sb);
        int guard = 0;
        while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        repeat (8) @(negedge clk);
        d = '0;
        for (int i = 0; i < (nb ? 9 : 8); i++) begin
            repeat (BIT_T) @(negedge clk);
            d[i] = txd;
        end
        repeat (BIT_T) @(negedge clk);
        sb = txd;
        repeat (8) @(negedge clk);
    endtask

    task automatic low_run(output int n);
        int guard = 0;
        n = 0;
        while (txd !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (txd === 1'b0 && n < 5000) begin @(negedge clk); n++; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R11: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] got, expd;
        logic       sb;
        int         n;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 txd", 16'(txd), 16'h1);
        chk("R11 tx_empty", 16'(tx_empty), 16'h1);
        chk("R11 tx_done", 16'(tx_done), 16'h1);
        chk("R11 rx_valid", 16'(rx_valid), 16'h0);
        chk("R11 rx_frame_err", 16'(ferr), 16'h0);
        chk("R11 rx_asleep", 16'(asleep), 16'h0);

        // Vector table: receive, then transmit the same character
        for (int i = 0; i < 6; i++) begin
            nine = VEC[i][10];
            repeat (20) @(negedge clk);
            send_rx(VEC[i][10], VEC[i][8:0], VEC[i][9], BIT_T);
            expd = VEC[i][10] ? VEC[i][8:0] : {1'b0, VEC[i][7:0]};
            chk("R2 rx_valid set", 16'(rx_valid), 16'h1);
            chk("R1 rx_data", 16'(rx_data), 16'(expd));
            chk("R5 frame_err", 16'(ferr), 16'(!VEC[i][9]));
            pulse_rd();
            chk("R2 rx_valid cleared", 16'(rx_valid), 16'h0);
            if (VEC[i][9]) begin
                fork
                    cap_tx(VEC[i][10], got, sb);
                    pulse_wr(VEC[i][8:0]);
                join
                chk("R1 tx data", 16'(got), 16'(expd));
                chk("R1 tx stop", 16'(sb), 16'h1);
            end
        end
        nine = 1'b0;
        repeat (40) @(negedge clk);

        // R3/R4: single wrong samples inside start and data bits
        send_glitch(8'hA5, 0);
        chk("R3 glitch on a one bit", 16'(rx_data), 16'h0A5);
        chk("R4 start glitch tolerated", 16'(rx_valid), 16'h1);
        pulse_rd();
        repeat (20) @(negedge clk);
        send_glitch(8'hA5, 1);
        chk("R3 glitch on a zero bit", 16'(rx_data), 16'h0A5);
        pulse_rd();

        // R4: short low pulse is discarded
        repeat (20) @(negedge clk);
        hold(1'b0, 3); hold(1'b1, 250);
        chk("R4 false start ignored", 16'(rx_valid), 16'h0);
        send_rx(1'b0, 9'h03C, 1'b1, BIT_T);
        chk("R4 receiver hunts again", 16'(rx_data), 16'h03C);
        pulse_rd();

        // R6: realignment for slow and fast senders
        repeat (20) @(negedge clk);
        send_rx(1'b0, 9'h055, 1'b1, 17);
        chk("R6 slow sender data", 16'(rx_data), 16'h055);
        chk("R6 slow sender stop", 16'(ferr), 16'h0);
        pulse_rd();
        repeat (20) @(negedge clk);
        send_rx(1'b0, 9'h055, 1'b1, 15);
        chk("R6 fast sender data", 16'(rx_data), 16'h055);
        chk("R6 fast sender stop", 16'(ferr), 16'h0);
        pulse_rd();

        // R7: standby with back-to-back frames, then wake after idle
        repeat (20) @(negedge clk);
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        chk("R7 asleep set", 16'(asleep), 16'h1);
        send_rx(1'b0, 9'h011, 1'b1, BIT_T);
        send_rx(1'b0, 9'h022, 1'b1, BIT_T);
        chk("R7 nothing delivered", 16'(rx_valid), 16'h0);
        chk("R7 data kept", 16'(rx_data), 16'h055);
        repeat (100) @(negedge clk);
        chk("R7 still asleep after short idle", 16'(asleep), 16'h1);
        repeat (100) @(negedge clk);
        chk("R7 awake after one character idle", 16'(asleep), 16'h0);
        send_rx(1'b0, 9'h033, 1'b1, BIT_T);
        chk("R7 next char delivered", 16'(rx_data), 16'h033);
        chk("R7 next char valid", 16'(rx_valid), 16'h1);
        pulse_rd();

        // R9/R10: queueing, ignored write when full, completion
        repeat (20) @(negedge clk);
        fork
            begin
                cap_tx(1'b0, got, sb);
                chk("R9 first frame", 16'(got), 16'h05A);
                cap_tx(1'b0, got, sb);
                chk("R9 second frame", 16'(got), 16'h0C3);
            end
            begin
                pulse_wr(9'h05A);
                repeat (2) @(negedge clk);
                chk("R9 empty after load", 16'(tx_empty), 16'h1);
                chk("R10 done low while sending", 16'(tx_done), 16'h0);
                pulse_wr(9'h0C3);
                pulse_wr(9'h077);
                chk("R9 slot full", 16'(tx_empty), 16'h0);
            end
        join
        n = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (txd == 1'b0) n++;
        end
        chk("R9 write into full slot ignored", 16'(n), 16'h0);
        chk("R10 done after last frame", 16'(tx_done), 16'h1);

        // R9: data beats break in the same cycle (break would make stop 0)
        fork
            cap_tx(1'b0, got, sb);
            begin
                wdata = 9'h000; wr = 1'b1; brk_req = 1'b1;
                @(negedge clk);
                wr = 1'b0; brk_req = 1'b0;
            end
        join
        chk("R9 priority data", 16'(got), 16'h000);
        chk("R9 priority stop", 16'(sb), 16'h1);
        repeat (40) @(negedge clk);

        // R8: idle character between two zero frames, fall-to-fall 2 x 160
        fork
            begin
                low_run(n);
                chk("R8 zero frame low run", 16'(n), 16'd144);
                n = 144;
                while (txd === 1'b1 && n < 5000) begin @(negedge clk); n++; end
                chk("R8 idle char no gap", 16'(n), 16'd320);
            end
            begin
                pulse_wr(9'h000);
                while (!tx_empty) @(negedge clk);
                idle_req = 1'b1; @(negedge clk); idle_req = 1'b0;
                while (!tx_empty) @(negedge clk);
                pulse_wr(9'h000);
            end
        join
        repeat (200) @(negedge clk);

        // R8: break length in both modes
        fork
            low_run(n);
            begin brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end
        join
        chk("R8 break 8-bit length", 16'(n), 16'd160);
        repeat (40) @(negedge clk);
        nine = 1'b1;
        fork
            low_run(n);
            begin brk_req = 1'b1; @(negedge clk); brk_req = 1'b0; end
        join
        chk("R8 break 9-bit length", 16'(n), 16'd176);
        repeat (20) @(negedge clk);
        chk("R10 done after break", 16'(tx_done), 16'h1);

        summary();
        $finish;
    end

endmodule